// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the 8-bit execution stage of a small accumulator machine. It owns the accumulator and a four-bit flag register holding zero, carry, half carry and signed overflow. Each clock it receives an already decoded operation code, one operand byte (a memory byte, an IO byte or a literal) and a destination select. It returns the result byte and a memory write strobe. It updates the accumulator and the flags on the rising edge.

Two-operand operations either put their result in the accumulator (destination select low) or send it back to memory (destination select high). Unary operations act on the accumulator or on the operand byte, as the same select chooses. Each operation changes only its own set of flags: the arithmetic group changes all four, the logic and load group changes zero only, shifts and rotates change carry only, and data moves change none. Fetch, the memory arrays and the program counter lie outside the block. `resultOut` and `memWrEn` depend combinationally on the inputs and the current state. `accOut` and `flagsOut` are registered.

Top module: `acc_alu`

## Requirements
- R1: Operation codes are NOP=0, ADD=1, SUB=2, ADDC=3, SUBC=4, NADD=5, CMP=6, AND=7, OR=8, XOR=9, NOT=10, NEG=11, SR=12, SL=13, SRC=14, SLC=15, SWAP=16, INC=17, DEC=18, CLR=19, LDA=20, STA=21, XCH=22, NLDA=23, NSTA=24. Codes 25 to 31 act as NOP. `flagsOut` bit 0 is zero, bit 1 carry, bit 2 half carry, bit 3 overflow. ADD computes A+operand and ADDC computes A+operand+carry. Carry is the carry out of bit 7, half carry is the carry out of bit 3, and overflow is set when both addends have the same sign and the sum's sign differs.
- R2: SUB and SUBC compute minuend−subtrahend, with SUBC also subtracting the carry flag. Carry is set on borrow (unsigned minuend < subtrahend + incoming carry). Half carry is set on a borrow out of bit 3. Overflow is set when the operands' signs differ and the result's sign differs from the minuend's.
- R3: With destination A, SUB computes A−M and NADD computes M−A. With destination memory, SUB computes M−A and NADD computes A−M. Both set all four flags by the R2 rules.
- R4: CMP sets all four flags from A−M (select low) or from M−A (select high). It never asserts `memWrEn` and leaves the accumulator unchanged.
- R5: AND, OR, XOR (A with operand) and NOT (of the target) write their result to the destination and update only the zero flag.
- R6: SR and SL shift in 0. SRC loads carry into bit 7 and SLC loads carry into bit 0. In all four, the bit shifted out goes to carry and no other flag changes.
- R7: SWAP exchanges the nibbles of the target, and CLR writes zero. XCH sends A to memory and loads the operand into A. None of the three changes a flag.
- R8: NEG writes the two's complement of the target and NLDA loads the negated operand into A. Both update only the zero flag. NSTA writes the negated A to memory and changes no flag.
- R9: LDA loads the operand into A and updates only the zero flag. STA writes A to memory and changes no flag. Both ignore the destination select.
- R10: INC and DEC add or subtract one from the target and update all four flags by the R1 and R2 rules.
- R11: With `opValid` low, or with an unused code, `memWrEn` stays low and the accumulator and flags hold.
- R12: After reset the accumulator and all flags are zero.
- R13: `memWrEn` is high exactly when the operation sends its result to memory. The accumulator changes only when A is the operation's destination, or on XCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 5 | Decoded operation code (R1) |
| dstMem | input | 1 | Destination / target select: 1 memory, 0 accumulator |
| operand | input | 8 | Memory, IO or literal byte |
| resultOut | output | 8 | Result byte for write-back |
| memWrEn | output | 1 | Result is to be written to memory |
| accOut | output | 8 | Accumulator contents |
| flagsOut | output | 4 | Flags {overflow, half carry, carry, zero} |

## Verification
A wrong accumulator or carry value appears at the ports one edge after the operation that caused it: on `accOut` and `flagsOut` directly, and on `resultOut` of the next operation that reads A or carry, in the same cycle that operation is presented. A flag that an operation should have left alone shows up as a changed `flagsOut` bit one edge later. The tests therefore set a flag deliberately to disagree with the result, for example zero held high across a shift that produces a non-zero byte.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_SUB  = 5'd2,  OP_ADDC = 5'd3,
    OP_SUBC = 5'd4,  OP_NADD = 5'd5,  OP_CMP  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_NOT  = 5'd10, OP_NEG  = 5'd11,
    OP_SR   = 5'd12, OP_SL   = 5'd13, OP_SRC  = 5'd14, OP_SLC  = 5'd15,
    OP_SWAP = 5'd16, OP_INC  = 5'd17, OP_DEC  = 5'd18, OP_CLR  = 5'd19,
    OP_LDA  = 5'd20, OP_STA  = 5'd21, OP_XCH  = 5'd22, OP_NLDA = 5'd23,
    OP_NSTA = 5'd24
  } aluOp_e;

  typedef enum logic [1:0] {X_ACC, X_OPD, X_ZERO} xSel_e;
  typedef enum logic [1:0] {Y_ACC, Y_OPD, Y_ONE}  ySel_e;

  typedef enum logic [3:0] {
    R_SUM, R_AND, R_OR, R_XOR, R_NOT, R_SHR, R_SHL, R_SWAP, R_ZERO, R_PASSY
  } resSel_e;

  typedef struct packed {
    xSel_e   xSel;
    ySel_e   ySel;
    logic    subMode;
    logic    useCarry;
    logic    rotate;
    resSel_e resSel;
    logic    toAcc;
    logic    toMem;
    logic    opdToAcc;
    logic    updZf;
    logic    updCf;
    logic    updAcOv;
  } strobes_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic           opValid,
  input  logic [OPW-1:0] opCode,
  input  logic           dstMem,
  output strobes_t       st
);

  xSel_e tgtX;
  ySel_e tgtY;
  assign tgtX = dstMem ? X_OPD : X_ACC;
  assign tgtY = dstMem ? Y_OPD : Y_ACC;

  always_comb begin
    st = '{xSel: X_ACC, ySel: Y_OPD, resSel: R_SUM, default: 1'b0};
    if (opValid) begin
      case (aluOp_e'(opCode))
        OP_ADD, OP_ADDC: begin
          st.useCarry = (aluOp_e'(opCode) == OP_ADDC);
          st.toAcc = !dstMem; st.toMem = dstMem;
          st.updZf = 1'b1; st.updCf = 1'b1; st.updAcOv = 1'b1;
        end
        OP_SUB, OP_SUBC, OP_CMP: begin
          st.xSel = dstMem ? X_OPD : X_ACC;
          st.ySel = dstMem ? Y_ACC : Y_OPD;
          st.subMode = 1'b1;
          st.useCarry = (aluOp_e'(opCode) == OP_SUBC);
          st.toAcc = !dstMem && (aluOp_e'(opCode) != OP_CMP);
          st.toMem = dstMem && (aluOp_e'(opCode) != OP_CMP);
          st.updZf = 1'b1; st.updCf = 1'b1; st.updAcOv = 1'b1;
        end
        OP_NADD: begin
          st.xSel = dstMem ? X_ACC : X_OPD;
          st.ySel = dstMem ? Y_OPD : Y_ACC;
          st.subMode = 1'b1;
          st.toAcc = !dstMem; st.toMem = dstMem;
          st.updZf = 1'b1; st.updCf = 1'b1; st.updAcOv = 1'b1;
        end
        OP_AND, OP_OR, OP_XOR: begin
          st.resSel = (aluOp_e'(opCode) == OP_AND) ? R_AND :
                      (aluOp_e'(opCode) == OP_OR)  ? R_OR  : R_XOR;
          st.toAcc = !dstMem; st.toMem = dstMem; st.updZf = 1'b1;
        end
        OP_NOT: begin
          st.xSel = tgtX; st.resSel = R_NOT;
          st.toAcc = !dstMem; st.toMem = dstMem; st.updZf = 1'b1;
        end
        OP_SR, OP_SL, OP_SRC, OP_SLC: begin
          st.xSel = tgtX;
          st.resSel = (aluOp_e'(opCode) == OP_SR || aluOp_e'(opCode) == OP_SRC) ? R_SHR : R_SHL;
          st.rotate = (aluOp_e'(opCode) == OP_SRC || aluOp_e'(opCode) == OP_SLC);
          st.toAcc = !dstMem; st.toMem = dstMem; st.updCf = 1'b1;
        end
        OP_SWAP, OP_CLR: begin
          st.xSel = tgtX;
          st.resSel = (aluOp_e'(opCode) == OP_SWAP) ? R_SWAP : R_ZERO;
          st.toAcc = !dstMem; st.toMem = dstMem;
        end
        OP_INC, OP_DEC: begin
          st.xSel = tgtX; st.ySel = Y_ONE;
          st.subMode = (aluOp_e'(opCode) == OP_DEC);
          st.toAcc = !dstMem; st.toMem = dstMem;
          st.updZf = 1'b1; st.updCf = 1'b1; st.updAcOv = 1'b1;
        end
        OP_NEG: begin
          st.xSel = X_ZERO; st.ySel = tgtY; st.subMode = 1'b1;
          st.toAcc = !dstMem; st.toMem = dstMem; st.updZf = 1'b1;
        end
        OP_LDA: begin
          st.ySel = Y_OPD; st.resSel = R_PASSY; st.toAcc = 1'b1; st.updZf = 1'b1;
        end
        OP_STA, OP_XCH: begin
          st.ySel = Y_ACC; st.resSel = R_PASSY; st.toMem = 1'b1;
          st.opdToAcc = (aluOp_e'(opCode) == OP_XCH);
        end
        OP_NLDA: begin
          st.xSel = X_ZERO; st.ySel = Y_OPD; st.subMode = 1'b1;
          st.toAcc = 1'b1; st.updZf = 1'b1;
        end
        OP_NSTA: begin
          st.xSel = X_ZERO; st.ySel = Y_ACC; st.subMode = 1'b1; st.toMem = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          memWrEn,
  output logic [DW-1:0] accOut,
  output logic [3:0]    flagsOut
);

  localparam int NIB = DW / 2;

  logic [DW-1:0] acc, x, y, yEff, sum;
  logic          zf, cf, ac, ov;
  logic          cinBit, carryOut, shIn, shOut;
  logic [NIB:0]  lowSum;
  logic          cfArith, acArith, ovArith;

  always_comb begin
    case (st.xSel)
      X_ACC:   x = acc;
      X_OPD:   x = operand;
      default: x = '0;
    endcase
    case (st.ySel)
      Y_ACC:   y = acc;
      Y_OPD:   y = operand;
      default: y = {{(DW-1){1'b0}}, 1'b1};
    endcase
  end

  assign yEff   = st.subMode ? ~y : y;
  assign cinBit = st.subMode ? ~(st.useCarry & cf) : (st.useCarry & cf);
  assign {carryOut, sum} = {1'b0, x} + {1'b0, yEff} + {{DW{1'b0}}, cinBit};
  assign lowSum = {1'b0, x[NIB-1:0]} + {1'b0, yEff[NIB-1:0]} + {{NIB{1'b0}}, cinBit};

  assign cfArith = st.subMode ? ~carryOut : carryOut;
  assign acArith = st.subMode ? ~lowSum[NIB] : lowSum[NIB];
  assign ovArith = (x[DW-1] == yEff[DW-1]) && (sum[DW-1] != x[DW-1]);

  assign shIn  = st.rotate & cf;
  assign shOut = (st.resSel == R_SHR) ? x[0] : x[DW-1];

  always_comb begin
    case (st.resSel)
      R_AND:   result = acc & operand;
      R_OR:    result = acc | operand;
      R_XOR:   result = acc ^ operand;
      R_NOT:   result = ~x;
      R_SHR:   result = {shIn, x[DW-1:1]};
      R_SHL:   result = {x[DW-2:0], shIn};
      R_SWAP:  result = {x[NIB-1:0], x[DW-1:NIB]};
      R_ZERO:  result = '0;
      R_PASSY: result = y;
      default: result = sum;
    endcase
  end

  assign memWrEn = st.toMem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      zf  <= 1'b0;
      cf  <= 1'b0;
      ac  <= 1'b0;
      ov  <= 1'b0;
    end else begin
      if (st.opdToAcc)   acc <= operand;
      else if (st.toAcc) acc <= result;
      if (st.updZf)      zf <= (result == '0);
      if (st.updCf)      cf <= (st.resSel == R_SUM) ? cfArith : shOut;
      if (st.updAcOv) begin
        ac <= acArith;
        ov <= ovArith;
      end
    end
  end

  assign accOut   = acc;
  assign flagsOut = {ov, ac, cf, zf};

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [OPW-1:0] opCode,
  input  logic           dstMem,
  input  logic [DW-1:0]  operand,
  output logic [DW-1:0]  resultOut,
  output logic           memWrEn,
  output logic [DW-1:0]  accOut,
  output logic [3:0]     flagsOut
);

  strobes_t st;

  acc_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .dstMem  (dstMem),
    .st      (st)
  );

  acc_alu_dp #(.DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .operand  (operand),
    .result   (resultOut),
    .memWrEn  (memWrEn),
    .accOut   (accOut),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           opValid,
  input logic [OPW-1:0] opCode,
  input logic           dstMem,
  input logic [DW-1:0]  operand,
  input logic [DW-1:0]  resultOut,
  input logic           memWrEn,
  input logic [DW-1:0]  accOut,
  input logic [3:0]     flagsOut
);

  logic isLogic, isShift, isQuiet, isArith;
  assign isLogic = opValid && (opCode == OP_AND || opCode == OP_OR ||
                               opCode == OP_XOR || opCode == OP_NOT);
  assign isShift = opValid && (opCode == OP_SR || opCode == OP_SL ||
                               opCode == OP_SRC || opCode == OP_SLC);
  assign isQuiet = opValid && (opCode == OP_SWAP || opCode == OP_CLR ||
                               opCode == OP_XCH || opCode == OP_STA || opCode == OP_NSTA);
  assign isArith = opValid && (opCode == OP_ADD || opCode == OP_SUB ||
                               opCode == OP_ADDC || opCode == OP_SUBC ||
                               opCode == OP_NADD || opCode == OP_INC || opCode == OP_DEC);

  // R11: no memory write and no state change while idle
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(accOut) && $stable(flagsOut));
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !memWrEn);

  // R4: compare never writes
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |-> !memWrEn);
  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> $stable(accOut));

  // R5: logic ops touch only zero
  a_r5_logic_zf_only: assert property (@(posedge clk) disable iff (!rstN)
    isLogic |=> $stable(flagsOut[3:1]));

  // R6: shifts touch only carry
  a_r6_shift_cf_only: assert property (@(posedge clk) disable iff (!rstN)
    isShift |=> $stable(flagsOut[0]) && $stable(flagsOut[3:2]));

  // R7: data moves leave the flags alone
  a_r7_move_no_flags: assert property (@(posedge clk) disable iff (!rstN)
    isQuiet |=> $stable(flagsOut));

  // R2: zero flag reflects the arithmetic result
  a_r2_zf_tracks_result: assert property (@(posedge clk) disable iff (!rstN)
    isArith |=> flagsOut[0] == ($past(resultOut) == '0));

  // R13: a memory-bound result leaves A untouched unless exchanging
  a_r13_mem_keeps_acc: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && opCode != OP_XCH) |=> $stable(accOut));

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .dstMem    (dstMem),
  .operand   (operand),
  .resultOut (resultOut),
  .memWrEn   (memWrEn),
  .accOut    (accOut),
  .flagsOut  (flagsOut)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  import acc_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = 5'd0;
  logic       dstMem = 1'b0;
  logic [7:0] operand = 8'd0;
  logic [7:0] resultOut, accOut;
  logic       memWrEn;
  logic [3:0] flagsOut;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .dstMem(dstMem), .operand(operand), .resultOut(resultOut),
    .memWrEn(memWrEn), .accOut(accOut), .flagsOut(flagsOut)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Present one operation, check the combinational outputs, then the registered state.
  task automatic runOp(input logic [4:0] op, input logic dm, input logic [7:0] opd,
                       input logic chkRes, input logic [7:0] expRes, input logic expWr,
                       input logic [7:0] expA, input logic [3:0] expF, input string tag,
                       input logic valid = 1'b1);
    @(negedge clk);
    opValid = valid; opCode = op; dstMem = dm; operand = opd;
    #2;
    if (chkRes) check(tag, "result", resultOut, expRes);
    check("R13", "memWrEn", memWrEn, expWr);
    @(posedge clk);
    #2;
    check(tag, "acc", accOut, expA);
    check(tag, "flags", flagsOut, expF);
    opValid = 1'b0;
  endtask

  task automatic testReset;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R12", "acc", accOut, 8'h00);
    check("R12", "flags", flagsOut, 4'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testAdd;
    runOp(OP_LDA, 0, 8'h7F, 1, 8'h7F, 0, 8'h7F, 4'b0000, "R9");
    runOp(OP_ADD, 0, 8'h01, 1, 8'h80, 0, 8'h80, 4'b1100, "R1");
    runOp(OP_ADD, 1, 8'h80, 1, 8'h00, 1, 8'h80, 4'b1011, "R1");
    runOp(OP_ADDC, 0, 8'h01, 1, 8'h82, 0, 8'h82, 4'b0000, "R1");
  endtask

  task automatic testSub;
    runOp(OP_LDA, 0, 8'h10, 1, 8'h10, 0, 8'h10, 4'b0000, "R9");
    runOp(OP_SUB, 0, 8'h01, 1, 8'h0F, 0, 8'h0F, 4'b0100, "R2");
    runOp(OP_SUB, 0, 8'h10, 1, 8'hFF, 0, 8'hFF, 4'b0010, "R2");
    runOp(OP_SUBC, 0, 8'h00, 1, 8'hFE, 0, 8'hFE, 4'b0000, "R2");
    runOp(OP_LDA, 0, 8'h80, 1, 8'h80, 0, 8'h80, 4'b0000, "R9");
    runOp(OP_SUB, 0, 8'h01, 1, 8'h7F, 0, 8'h7F, 4'b1100, "R2");
  endtask

  task automatic testOrder;
    runOp(OP_SUB,  1, 8'h05, 1, 8'h86, 1, 8'h7F, 4'b0110, "R3");
    runOp(OP_NADD, 0, 8'h90, 1, 8'h11, 0, 8'h11, 4'b1100, "R3");
    runOp(OP_NADD, 1, 8'h20, 1, 8'hF1, 1, 8'h11, 4'b0010, "R3");
  endtask

  task automatic testCmp;
    runOp(OP_CMP, 0, 8'h11, 0, 8'h00, 0, 8'h11, 4'b0001, "R4");
    runOp(OP_CMP, 1, 8'h10, 0, 8'h00, 0, 8'h11, 4'b0110, "R4");
  endtask

  task automatic testLogic;
    runOp(OP_AND, 0, 8'h22, 1, 8'h00, 0, 8'h00, 4'b0111, "R5");
    runOp(OP_OR,  1, 8'h0F, 1, 8'h0F, 1, 8'h00, 4'b0110, "R5");
    runOp(OP_XOR, 0, 8'hFF, 1, 8'hFF, 0, 8'hFF, 4'b0110, "R5");
    runOp(OP_NOT, 0, 8'h5A, 1, 8'h00, 0, 8'h00, 4'b0111, "R5");
  endtask

  task automatic testShift;
    runOp(OP_SR,  1, 8'h81, 1, 8'h40, 1, 8'h00, 4'b0111, "R6");
    runOp(OP_SRC, 1, 8'h02, 1, 8'h81, 1, 8'h00, 4'b0101, "R6");
    runOp(OP_SL,  1, 8'hC0, 1, 8'h80, 1, 8'h00, 4'b0111, "R6");
    runOp(OP_SLC, 1, 8'h01, 1, 8'h03, 1, 8'h00, 4'b0101, "R6");
  endtask

  task automatic testMoves;
    runOp(OP_LDA,  0, 8'h3C, 1, 8'h3C, 0, 8'h3C, 4'b0100, "R9");
    runOp(OP_SWAP, 0, 8'h00, 1, 8'hC3, 0, 8'hC3, 4'b0100, "R7");
    runOp(OP_SWAP, 1, 8'h12, 1, 8'h21, 1, 8'hC3, 4'b0100, "R7");
    runOp(OP_CLR,  1, 8'h77, 1, 8'h00, 1, 8'hC3, 4'b0100, "R7");
    runOp(OP_XCH,  1, 8'h55, 1, 8'hC3, 1, 8'h55, 4'b0100, "R7");
  endtask

  task automatic testNeg;
    runOp(OP_NEG,  0, 8'h00, 1, 8'hAB, 0, 8'hAB, 4'b0100, "R8");
    runOp(OP_NEG,  1, 8'h00, 1, 8'h00, 1, 8'hAB, 4'b0101, "R8");
    runOp(OP_NLDA, 0, 8'h01, 1, 8'hFF, 0, 8'hFF, 4'b0100, "R8");
    runOp(OP_NSTA, 0, 8'h33, 1, 8'h01, 1, 8'hFF, 4'b0100, "R8");
  endtask

  task automatic testLoadStore;
    runOp(OP_LDA, 1, 8'h00, 1, 8'h00, 0, 8'h00, 4'b0101, "R9");
    runOp(OP_XCH, 0, 8'h44, 1, 8'h00, 1, 8'h44, 4'b0101, "R7");
    runOp(OP_STA, 0, 8'h99, 1, 8'h44, 1, 8'h44, 4'b0101, "R9");
  endtask

  task automatic testIncDec;
    runOp(OP_INC, 1, 8'hFF, 1, 8'h00, 1, 8'h44, 4'b0111, "R10");
    runOp(OP_DEC, 0, 8'h00, 1, 8'h43, 0, 8'h43, 4'b0000, "R10");
    runOp(OP_DEC, 1, 8'h80, 1, 8'h7F, 1, 8'h43, 4'b1100, "R10");
  endtask

  task automatic testIdle;
    runOp(OP_ADD, 1, 8'h12, 0, 8'h00, 0, 8'h43, 4'b1100, "R11", 1'b0);
    runOp(5'd27, 1, 8'h12, 0, 8'h00, 0, 8'h43, 4'b1100, "R11");
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testAdd();
    testSub();
    testOrder();
    testCmp();
    testLogic();
    testShift();
    testMoves();
    testNeg();
    testLoadStore();
    testIncDec();
    testIdle();
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule